// File: doc/BRIEF.md
# Accelerator Command Register Bank and Launch Sequencer

This block is the host-facing control point of a layer accelerator. A host reaches it over an AXI4-Lite slave port and programs six layer parameters: input channel count, output channel count, input feature-map size, kernel size, operating mode and image base address. It then writes a launch word. Only one exact 32-bit code counts as a launch. When that code arrives while the block is idle, the parameters are copied into a working set. That copy drives the datapath for the whole operation.

The mode word picks one of two engine controllers: a convolution engine or a fully connected engine. The chosen engine gets a one-cycle go pulse. The block then waits for that engine's one-cycle done pulse and raises a completion flag, which the host reads back. Each engine is reduced here to a go/done pair of plain pins.

On the bus side, a write is taken only when address and data are presented together. The host holds AWVALID and WVALID until AWREADY/WREADY rise. BVALID then stays high until BREADY, and no further write is taken while it is high. A read is taken when ARREADY is high, which happens only while no read response is pending. RVALID and RDATA then hold until RREADY.

Top module: `accel_cmd_regs`

## Requirements
- R1: A write is accepted in the cycle where AWVALID and WVALID are both high and no write response is pending. BVALID rises the next cycle with BRESP = 2'b00 (OKAY) and stays high until BREADY. AWREADY and WREADY stay low while BVALID is high.
- R2: ARREADY is high exactly when no read response is pending. RVALID rises the cycle after a read is accepted, with RRESP = 2'b00. RVALID and RDATA hold until RREADY.
- R3: The parameter words are word indices 0 to 5 (byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14). They reset to zero and read back what was written. Byte lane n (data bits 8n+7:8n) is updated only when WSTRB[n] is 1.
- R4: Word 6 (offset 0x18) is the launch word. A write there starts an operation only if its data, masked by WSTRB, equals 0xF0000000. Any other value does nothing. This word always reads as zero, so one write starts exactly one operation.
- R5: Word 4 bit 0 selects the engine: 0 for convolution, 1 for fully connected. In the cycle after an accepted launch, exactly one of conv_go and fc_go is high, for exactly one cycle.
- R6: Word 7 (offset 0x1C) reads {31'b0, done}. The done flag is set by the done pulse of the engine that was launched. It is cleared when a launch is accepted. A done pulse from the other engine is ignored.
- R7: Writes to word 7 are ignored.
- R8: The act_* outputs take the parameter words when a launch is accepted and then stay constant. Parameter writes during an operation change only what the host reads back. A launch code written while an operation is running is ignored.
- R9: Offsets 0x20 and above answer OKAY. Writes to them have no effect and reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| conv_go | output | 1 | One-cycle launch pulse to the convolution engine |
| conv_done | input | 1 | One-cycle completion pulse from the convolution engine |
| fc_go | output | 1 | One-cycle launch pulse to the fully connected engine |
| fc_done | input | 1 | One-cycle completion pulse from the fully connected engine |
| act_in_ch | output | 32 | Working input channel count |
| act_out_ch | output | 32 | Working output channel count |
| act_map_size | output | 32 | Working feature-map size |
| act_kernel | output | 32 | Working kernel size |
| act_img_base | output | 32 | Working image base address |

## Verification
Take the edge where a write or read handshake happens as edge k.
- After edge k, BVALID, RVALID and RDATA are already valid.
- The go pulse is high in the cycle after edge k, and the act_* outputs change at edge k.
- The done flag becomes readable after the edge that samples the engine's done pulse.

The bench drives inputs and samples outputs on falling edges. It checks each result at the first falling edge after the edge that produces it. It checks that a result has gone, such as the end of a go pulse or a stale launch, one or more falling edges later. Effects that are only visible in stored state, such as ignored writes and completion, are read back through the bus.

// File: rtl/acr_pkg.sv
package acr_pkg;
  localparam int DATA_W     = 32;
  localparam int STRB_W     = DATA_W / 8;
  localparam int NUM_WORDS  = 8;
  localparam int NUM_PARAMS = 6;
  localparam int IDX_W      = $clog2(NUM_WORDS);
  localparam int WORD_LSB   = 2;
  localparam int MAP_BITS   = IDX_W + WORD_LSB;

  localparam logic [IDX_W-1:0] IDX_IN_CH  = 3'd0;
  localparam logic [IDX_W-1:0] IDX_OUT_CH = 3'd1;
  localparam logic [IDX_W-1:0] IDX_MAP    = 3'd2;
  localparam logic [IDX_W-1:0] IDX_KERNEL = 3'd3;
  localparam logic [IDX_W-1:0] IDX_MODE   = 3'd4;
  localparam logic [IDX_W-1:0] IDX_BASE   = 3'd5;
  localparam logic [IDX_W-1:0] IDX_START  = 3'd6;
  localparam logic [IDX_W-1:0] IDX_DONE   = 3'd7;

  localparam logic [DATA_W-1:0] LAUNCH_CODE = 32'hF000_0000;
  localparam logic [1:0]        RESP_OKAY   = 2'b00;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_LAUNCH = 2'd1,
    SEQ_RUN    = 2'd2
  } seq_state_t;

  function automatic logic [DATA_W-1:0] lane_mask(input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] m;
    for (int b = 0; b < STRB_W; b++) m[b*8 +: 8] = {8{strb[b]}};
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] lane_merge(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] new_v,
                                                   input logic [STRB_W-1:0] strb);
    logic [DATA_W-1:0] m;
    m = lane_mask(strb);
    return (old_v & ~m) | (new_v & m);
  endfunction
endpackage

// File: rtl/acr_axil_port.sv
module acr_axil_port
  import acr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [STRB_W-1:0] wr_strb,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_word
);
  logic rd_fire;

  // Address and data are taken together, one outstanding response at most.
  assign wr_fire = awvalid && wvalid && !bvalid;
  assign awready = wr_fire;
  assign wready  = wr_fire;
  assign wr_addr = awaddr;
  assign wr_data = wdata;
  assign wr_strb = wstrb;
  assign bresp   = RESP_OKAY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bvalid <= 1'b0;
    else if (wr_fire) bvalid <= 1'b1;
    else if (bready)  bvalid <= 1'b0;
  end

  assign arready = !rvalid;
  assign rd_fire = arvalid && arready;
  assign rd_addr = araddr;
  assign rresp   = RESP_OKAY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (rd_fire) begin
      rvalid <= 1'b1;
      rdata  <= rd_word;
    end else if (rready) begin
      rvalid <= 1'b0;
    end
  end

  // R1: response held until taken, no second write while pending
  assert_bvalid_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid);
  assert_no_write_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> !awready && !wready);
  assert_bvalid_after_fire_R1: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && wvalid && awready |=> bvalid);
  // R2: read response held and stable until taken
  assert_rvalid_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
  assert_rvalid_after_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
    arvalid && arready |=> rvalid);
endmodule

// File: rtl/acr_reg_bank.sv
module acr_reg_bank
  import acr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              done_flag,
  output logic [DATA_W-1:0] rd_word,
  output logic [DATA_W-1:0] param_q [NUM_PARAMS],
  output logic              launch_hit
);
  logic             wr_mapped, rd_mapped;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             unused_addr_bits;

  assign wr_mapped = (wr_addr >> MAP_BITS) == '0;
  assign rd_mapped = (rd_addr >> MAP_BITS) == '0;
  assign wr_idx    = wr_addr[MAP_BITS-1:WORD_LSB];
  assign rd_idx    = rd_addr[MAP_BITS-1:WORD_LSB];
  assign unused_addr_bits = ^{wr_addr[WORD_LSB-1:0], rd_addr[WORD_LSB-1:0]};

  for (genvar p = 0; p < NUM_PARAMS; p++) begin : g_param
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        param_q[p] <= '0;
      else if (wr_fire && wr_mapped && wr_idx == IDX_W'(p))
        param_q[p] <= lane_merge(param_q[p], wr_data, wr_strb);
    end
  end

  // The launch word keeps no storage: only the strobe-masked value is compared.
  assign launch_hit = wr_fire && wr_mapped && (wr_idx == IDX_START) &&
                      ((wr_data & lane_mask(wr_strb)) == LAUNCH_CODE);

  always_comb begin
    rd_word = '0;
    if (rd_mapped) begin
      case (rd_idx)
        IDX_IN_CH:  rd_word = param_q[0];
        IDX_OUT_CH: rd_word = param_q[1];
        IDX_MAP:    rd_word = param_q[2];
        IDX_KERNEL: rd_word = param_q[3];
        IDX_MODE:   rd_word = param_q[4];
        IDX_BASE:   rd_word = param_q[5];
        IDX_DONE:   rd_word = {{(DATA_W-1){1'b0}}, done_flag};
        default:    rd_word = '0;
      endcase
    end
  end

  // R9 / R3: unmapped or unwritten offsets leave parameter words untouched
  assert_unmapped_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && !wr_mapped |=> $stable(param_q[0]) && $stable(param_q[5]));
  // R4: launch only on the exact word index
  assert_launch_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
    launch_hit |-> wr_idx == IDX_START);
endmodule

// File: rtl/acr_sequencer.sv
module acr_sequencer
  import acr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_hit,
  input  logic [DATA_W-1:0] param_q [NUM_PARAMS],
  input  logic              conv_done,
  input  logic              fc_done,
  output logic              conv_go,
  output logic              fc_go,
  output logic              done_flag,
  output logic [DATA_W-1:0] work_q [NUM_PARAMS]
);
  seq_state_t state;
  logic       mode_fc;
  logic       accept;
  logic       engine_done;
  logic       unused_mode_bits;

  assign accept      = launch_hit && (state == SEQ_IDLE);
  assign mode_fc     = work_q[IDX_MODE][0];
  assign engine_done = mode_fc ? fc_done : conv_done;
  assign unused_mode_bits = ^work_q[IDX_MODE][DATA_W-1:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      done_flag <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: if (accept) begin
          state     <= SEQ_LAUNCH;
          done_flag <= 1'b0;
        end
        SEQ_LAUNCH: state <= SEQ_RUN;
        SEQ_RUN: if (engine_done) begin
          state     <= SEQ_IDLE;
          done_flag <= 1'b1;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  for (genvar p = 0; p < NUM_PARAMS; p++) begin : g_work
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      work_q[p] <= '0;
      else if (accept) work_q[p] <= param_q[p];
    end
  end

  assign conv_go = (state == SEQ_LAUNCH) && !mode_fc;
  assign fc_go   = (state == SEQ_LAUNCH) &&  mode_fc;

  // R5: one engine at a time, one-cycle pulses
  assert_go_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({conv_go, fc_go}));
  assert_conv_go_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_go |=> !conv_go);
  assert_fc_go_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fc_go |=> !fc_go);
  assert_go_follows_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> conv_go || fc_go);
  // R6: accepted launch clears completion; foreign done pulse ignored
  assert_done_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !done_flag);
  assert_foreign_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_RUN) && !engine_done |=> !done_flag);
  // R8: working set frozen outside acceptance; launch while running ignored
  assert_work_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(work_q[0]) && $stable(work_q[5]) && $stable(mode_fc));
  assert_busy_launch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    launch_hit && (state == SEQ_RUN) && !engine_done |=> !conv_go && !fc_go);
endmodule

// File: rtl/accel_cmd_regs.sv
module accel_cmd_regs
  import acr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [31:0]       s_wdata,
  input  logic [3:0]        s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [31:0]       s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              conv_go,
  input  logic              conv_done,
  output logic              fc_go,
  input  logic              fc_done,
  output logic [31:0]       act_in_ch,
  output logic [31:0]       act_out_ch,
  output logic [31:0]       act_map_size,
  output logic [31:0]       act_kernel,
  output logic [31:0]       act_img_base
);
  logic              wr_fire, launch_hit, done_flag;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_word;
  logic [STRB_W-1:0] wr_strb;
  logic [DATA_W-1:0] param_q [NUM_PARAMS];
  logic [DATA_W-1:0] work_q  [NUM_PARAMS];

  acr_axil_port #(.ADDR_W(ADDR_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_addr(rd_addr), .rd_word(rd_word)
  );

  acr_reg_bank #(.ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_addr(rd_addr), .done_flag(done_flag), .rd_word(rd_word),
    .param_q(param_q), .launch_hit(launch_hit)
  );

  acr_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .launch_hit(launch_hit), .param_q(param_q),
    .conv_done(conv_done), .fc_done(fc_done),
    .conv_go(conv_go), .fc_go(fc_go), .done_flag(done_flag), .work_q(work_q)
  );

  assign act_in_ch    = work_q[0];
  assign act_out_ch   = work_q[1];
  assign act_map_size = work_q[2];
  assign act_kernel   = work_q[3];
  assign act_img_base = work_q[5];
endmodule

// File: tb/accel_cmd_regs_tb.sv
module accel_cmd_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [ADDR_W-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 1, arvalid = 0, rready = 1;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic conv_go, fc_go;
  logic conv_done = 0, fc_done = 0;
  logic [31:0] act_in_ch, act_out_ch, act_map_size, act_kernel, act_img_base;

  int n_checks = 0;
  int n_fail   = 0;
  int conv_go_cnt = 0;
  int fc_go_cnt   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (conv_go) conv_go_cnt <= conv_go_cnt + 1;
    if (fc_go)   fc_go_cnt   <= fc_go_cnt + 1;
  end

  accel_cmd_regs #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .conv_go(conv_go), .conv_done(conv_done), .fc_go(fc_go), .fc_done(fc_done),
    .act_in_ch(act_in_ch), .act_out_ch(act_out_ch), .act_map_size(act_map_size),
    .act_kernel(act_kernel), .act_img_base(act_img_base)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Ends at the falling edge right after the handshake edge.
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s);
    awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1; bready = 1;
    while (!awready) @(negedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    check("R1 bvalid after write", {31'b0, bvalid}, 32'd1);
    check("R1 bresp okay", {30'b0, bresp}, 32'd0);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    araddr = a; arvalid = 1; rready = 1;
    while (!arready) @(negedge clk);
    @(negedge clk);
    arvalid = 0;
    check("R2 rvalid after read", {31'b0, rvalid}, 32'd1);
    check("R2 rresp okay", {30'b0, rresp}, 32'd0);
    d = rdata;
    @(negedge clk);
  endtask

  task automatic expect_read(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(tag, v, exp);
  endtask

  task automatic pulse_done(input bit fc);
    if (fc) fc_done = 1; else conv_done = 1;
    @(negedge clk);
    fc_done = 0; conv_done = 0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check("R5 conv_go low after reset", {31'b0, conv_go}, 32'd0);
    check("R8 act_in_ch reset", act_in_ch, 32'd0);
    for (int i = 0; i < 8; i++) expect_read("R3 reset readback", 8'(i*4), 32'd0);
  endtask

  task automatic t_param_strobes;
    bus_write(8'h00, 32'h1122_3344, 4'hF);
    expect_read("R3 full word", 8'h00, 32'h1122_3344);
    bus_write(8'h04, 32'hAABB_CCDD, 4'b0101);
    expect_read("R3 byte lanes", 8'h04, 32'h00BB_00DD);
  endtask

  task automatic t_unmapped;
    bus_write(8'h40, 32'hDEAD_BEEF, 4'hF);
    expect_read("R9 unmapped reads zero", 8'h40, 32'd0);
    expect_read("R9 no alias write", 8'h00, 32'h1122_3344);
  endtask

  task automatic t_bad_launch;
    bus_write(8'h18, 32'hF000_0001, 4'hF);
    repeat (3) @(negedge clk);
    check("R4 wrong code no conv go", 32'(conv_go_cnt), 32'd0);
    check("R4 wrong code no fc go", 32'(fc_go_cnt), 32'd0);
    expect_read("R4 launch word reads zero", 8'h18, 32'd0);
  endtask

  task automatic t_conv_run;
    bus_write(8'h08, 32'd28, 4'hF);
    bus_write(8'h0C, 32'd3, 4'hF);
    bus_write(8'h10, 32'd0, 4'hF);
    bus_write(8'h14, 32'h8000_0000, 4'hF);
    bus_write(8'h18, 32'hF000_0000, 4'hF);
    check("R5 conv_go after launch", {31'b0, conv_go}, 32'd1);
    check("R5 fc_go stays low", {31'b0, fc_go}, 32'd0);
    @(negedge clk);
    check("R5 conv_go one cycle", {31'b0, conv_go}, 32'd0);
    check("R8 act_in_ch latched", act_in_ch, 32'h1122_3344);
    check("R8 act_out_ch latched", act_out_ch, 32'h00BB_00DD);
    check("R8 act_map_size latched", act_map_size, 32'd28);
    check("R8 act_kernel latched", act_kernel, 32'd3);
    check("R8 act_img_base latched", act_img_base, 32'h8000_0000);
    bus_write(8'h00, 32'd7, 4'hF);
    @(negedge clk);
    check("R8 busy write keeps act_in_ch", act_in_ch, 32'h1122_3344);
    expect_read("R8 busy write reads back", 8'h00, 32'd7);
    bus_write(8'h18, 32'hF000_0000, 4'hF);
    repeat (2) @(negedge clk);
    check("R8 busy launch ignored", 32'(conv_go_cnt), 32'd1);
    expect_read("R6 not done while running", 8'h1C, 32'd0);
    pulse_done(1'b1);
    expect_read("R6 foreign done ignored", 8'h1C, 32'd0);
    pulse_done(1'b0);
    expect_read("R6 done set", 8'h1C, 32'd1);
    bus_write(8'h1C, 32'd0, 4'hF);
    expect_read("R7 completion write ignored", 8'h1C, 32'd1);
    check("R4 one launch one go", 32'(conv_go_cnt), 32'd1);
  endtask

  task automatic t_fc_run;
    bus_write(8'h10, 32'd1, 4'hF);
    bus_write(8'h18, 32'hF0AB_CDEF, 4'b1000);
    check("R5 fc_go after masked launch", {31'b0, fc_go}, 32'd1);
    check("R5 conv_go stays low", {31'b0, conv_go}, 32'd0);
    @(negedge clk);
    check("R8 relatch act_in_ch", act_in_ch, 32'd7);
    expect_read("R6 done cleared on launch", 8'h1C, 32'd0);
    pulse_done(1'b0);
    expect_read("R6 conv done ignored in fc", 8'h1C, 32'd0);
    pulse_done(1'b1);
    expect_read("R6 fc done set", 8'h1C, 32'd1);
    check("R5 fc go count", 32'(fc_go_cnt), 32'd1);
    check("R5 conv go count", 32'(conv_go_cnt), 32'd1);
  endtask

  task automatic t_bresp_hold;
    awaddr = 8'h08; wdata = 32'd5; wstrb = 4'hF; awvalid = 1; wvalid = 1; bready = 0;
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    repeat (2) @(negedge clk);
    check("R1 bvalid held", {31'b0, bvalid}, 32'd1);
    awaddr = 8'h0C; wdata = 32'd9; awvalid = 1; wvalid = 1;
    #1;
    check("R1 awready low while pending", {31'b0, awready}, 32'd0);
    @(negedge clk);
    bready = 1;
    @(negedge clk);
    check("R1 second write taken after bready", {31'b0, awready}, 32'd1);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    @(negedge clk);
    expect_read("R1 held write landed", 8'h08, 32'd5);
    expect_read("R1 second write landed", 8'h0C, 32'd9);
  endtask

  task automatic t_rresp_hold;
    logic [31:0] first;
    araddr = 8'h14; arvalid = 1; rready = 0;
    @(negedge clk);
    arvalid = 0;
    first = rdata;
    repeat (2) @(negedge clk);
    check("R2 rvalid held", {31'b0, rvalid}, 32'd1);
    check("R2 rdata stable", rdata, first);
    check("R2 rdata value", rdata, 32'h8000_0000);
    check("R2 arready low while pending", {31'b0, arready}, 32'd0);
    rready = 1;
    @(negedge clk);
    check("R2 rvalid drops", {31'b0, rvalid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_param_strobes();
    t_unmapped();
    t_bad_launch();
    t_conv_run();
    t_fc_run();
    t_bresp_hold();
    t_rresp_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule